// File: doc/BRIEF.md
# I2C Page-Buffered Memory Write Slave

This block is the write side of an I2C slave placed in front of a small non-volatile byte array. It watches the clock and data lines and drives data through an open-drain enable. It finds START and STOP conditions and accepts a device-select byte whose chip-select field must match three strap pins. It then takes a 16-bit word pointer, most significant byte first, followed by one data byte or a burst of data bytes. The data bytes collect in a one-page buffer.

A page covers 64 consecutive bytes. During a burst, only the six low pointer bits advance, and they wrap inside the page. When more than a page of data arrives, the newest byte for a location replaces the older one. Nothing reaches the array until the master closes the transaction with STOP. The block then enters a programming phase that lasts a parameterised number of clock cycles. At the end of that phase, every buffered byte is written into the array in the same cycle. The slave ignores the bus for the whole programming phase. A read path elsewhere reads the array through a combinational read port.

The controller is one state machine. Its states are: `S_IDLE` (wait for START), `S_DEV` (shift in the device byte), `S_ACK_DEV`, `S_AHI` (pointer high byte), `S_ACK_HI`, `S_ALO` (pointer low byte), `S_ACK_LO`, `S_DATA` (data byte), `S_ACK_DATA` and `S_PROG` (programming countdown).

Its transitions are:
- START from any state except `S_PROG` leads to `S_DEV`.
- STOP leads to `S_PROG` when the buffer holds data, and to `S_IDLE` when it does not.
- In `S_DEV`, the end of a byte leads to `S_ACK_DEV` on a match and to `S_IDLE` otherwise.
- In each of the other receive states, the end of a byte leads to its acknowledge state.
- Each acknowledge state moves on at the falling SCL edge that ends the ninth clock: `S_ACK_DEV`→`S_AHI`, `S_ACK_HI`→`S_ALO`, `S_ACK_LO`→`S_DATA`, `S_ACK_DATA`→`S_DATA`.
- `S_PROG` returns to `S_IDLE` when its count runs out.

Top module: `i2c_page_write_slave`

## Requirements
- R1: A device byte is accepted when bits 7:4 equal 1010, bits 3:1 equal `strap[2:0]` and bit 0 (R/W) is 0. The slave acknowledges it by holding `sda_oe` high across the ninth SCL clock.
- R2: A device byte whose bits 7:4 differ from 1010 gets no acknowledge. No later byte is acknowledged until the next START.
- R3: A device byte whose bits 3:1 differ from the straps, or whose R/W bit is 1, gets no acknowledge.
- R4: After the device byte, two pointer bytes follow, high byte first, and each is acknowledged. The array location used is the low `MEM_AW` bits of the 16-bit pointer.
- R5: Every data byte received in a write transaction is acknowledged.
- R6: After each data byte, the low 6 pointer bits increment modulo 64. The pointer bits above them stay unchanged for the rest of the transaction.
- R7: When more than 64 data bytes arrive before STOP, writing wraps within the page. Each location keeps the last byte written to it.
- R8: The array does not change before STOP. A STOP after at least one data byte raises `busy` for exactly `PROG_CYCLES` cycles. All buffered bytes are written to the array together when that count ends.
- R9: While `busy` is high, the slave does not acknowledge its device byte and ignores the bus.
- R10: A START or repeated START before STOP discards the buffered data without programming. A STOP with no data byte received leaves `busy` low.
- R11: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bits are sampled on the rising SCL edge, and `sda_oe` changes only while SCL is low.
- R12: While reset is asserted and after it is released, `sda_oe` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the pin |
| strap | input | 3 | Chip-select straps compared with device byte bits 3:1 |
| sda_oe | output | 1 | Pulls the data line low when high (acknowledge) |
| busy | output | 1 | Programming phase in progress |
| rd_addr | input | MEM_AW | Array read address for the read path |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
A wrong state shows up on `sda_oe` within one byte time. A missing or extra acknowledge appears in the ninth clock of the byte the master is sending at that moment. A corrupted pointer or page buffer stays hidden until the programming phase ends. It then appears on `rd_data`, either at the wrong location or as a missing byte. A miscounted programming phase shows as a wrong `busy` length, known the cycle `busy` falls.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_ACK_DEV,
        S_AHI,
        S_ACK_HI,
        S_ALO,
        S_ACK_LO,
        S_DATA,
        S_ACK_DATA,
        S_PROG
    } wst_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/i2cw_line_cond.sv
// Synchronises SCL/SDA and derives edge and bus-condition strobes.
module i2cw_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_p, sda_p, scl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda};
            scl_p  <= scl_sh[SYNC_STAGES-1];
            sda_p  <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_q     = scl_sh[SYNC_STAGES-1];
    assign sda_q     = sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_q & ~scl_p;
    assign scl_fall  = ~scl_q & scl_p;
    assign start_evt = scl_q & scl_p & sda_p & ~sda_q;
    assign stop_evt  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2cw_page_buf.sv
// One page of pending bytes with a per-slot valid mask.
module i2cw_page_buf #(
    parameter int PAGE_AW = 6,
    parameter int DW      = 8,
    localparam int PAGE_N = 1 << PAGE_AW
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         wr_en,
    input  logic [PAGE_AW-1:0]           wr_idx,
    input  logic [DW-1:0]                wr_data,
    output logic [PAGE_N-1:0][DW-1:0]    page_q,
    output logic [PAGE_N-1:0]            valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     valid <= '0;
        else if (clr)   valid <= '0;
        else if (wr_en) valid[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) page_q[wr_idx] <= wr_data;
    end
endmodule

// File: rtl/i2cw_nv_array.sv
// Byte array; a commit writes every valid page slot in one cycle.
module i2cw_nv_array #(
    parameter int MEM_AW  = 9,
    parameter int PAGE_AW = 6,
    parameter int DW      = 8,
    localparam int PAGE_N = 1 << PAGE_AW,
    localparam int MEM_N  = 1 << MEM_AW
) (
    input  logic                         clk,
    input  logic                         commit,
    input  logic [MEM_AW-PAGE_AW-1:0]    page_sel,
    input  logic [PAGE_N-1:0][DW-1:0]    page_q,
    input  logic [PAGE_N-1:0]            valid,
    input  logic [MEM_AW-1:0]            rd_addr,
    output logic [DW-1:0]                rd_data
);
    logic [DW-1:0] mem [MEM_N];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE_N; i++) begin
                if (valid[i]) mem[{page_sel, PAGE_AW'(i)}] <= page_q[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2c_page_write_slave.sv
module i2c_page_write_slave
    import i2cw_pkg::*;
#(
    parameter int MEM_AW      = 9,
    parameter int PAGE_AW     = 6,
    parameter int PROG_CYCLES = 200,
    localparam int PAGE_N     = 1 << PAGE_AW,
    localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda_in,
    input  logic [2:0]        strap,
    output logic              sda_oe,
    output logic              busy,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    wst_t state, nxt;
    logic sda_q, scl_rise, scl_fall, start_evt, stop_evt;
    logic [7:0] sh;
    logic [3:0] bitn;
    logic [MEM_AW-1:0] ptr;
    logic [CNT_W-1:0] prog_cnt;
    logic rx_state, byte_end, addr_ok, buf_wr, buf_clr, buf_any, commit;
    logic [PAGE_N-1:0][7:0] page_q;
    logic [PAGE_N-1:0] valid;

    i2cw_line_cond #(.SYNC_STAGES(2)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_in), .sda_q(sda_q),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    assign rx_state = (state == S_DEV) || (state == S_AHI) ||
                      (state == S_ALO) || (state == S_DATA);
    assign byte_end = rx_state && scl_fall && (bitn == 4'd8);
    assign addr_ok  = (sh[7:4] == DEV_TYPE) && (sh[3:1] == strap) && !sh[0];
    assign buf_any  = |valid;
    assign commit   = (state == S_PROG) && (prog_cnt == '0);
    assign buf_wr   = (state == S_DATA) && byte_end && !start_evt && !stop_evt;
    assign buf_clr  = (start_evt && state != S_PROG) || commit;

    // Next-state logic
    always_comb begin
        nxt = state;
        if (state == S_PROG) begin
            nxt = commit ? S_IDLE : S_PROG;
        end else if (start_evt) begin
            nxt = S_DEV;
        end else if (stop_evt) begin
            nxt = buf_any ? S_PROG : S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:     nxt = S_IDLE;
                S_DEV:      if (byte_end) nxt = addr_ok ? S_ACK_DEV : S_IDLE;
                S_ACK_DEV:  if (scl_fall) nxt = S_AHI;
                S_AHI:      if (byte_end) nxt = S_ACK_HI;
                S_ACK_HI:   if (scl_fall) nxt = S_ALO;
                S_ALO:      if (byte_end) nxt = S_ACK_LO;
                S_ACK_LO:   if (scl_fall) nxt = S_DATA;
                S_DATA:     if (byte_end) nxt = S_ACK_DATA;
                S_ACK_DATA: if (scl_fall) nxt = S_DATA;
                S_PROG:     nxt = S_PROG;
            endcase
        end
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            sh       <= '0;
            bitn     <= '0;
            ptr      <= '0;
            prog_cnt <= '0;
        end else begin
            state <= nxt;
            if (state != S_PROG && (start_evt || byte_end)) begin
                bitn <= '0;
            end else if (rx_state && scl_rise) begin
                sh   <= {sh[6:0], sda_q};
                bitn <= bitn + 4'd1;
            end
            if (byte_end && state == S_AHI) ptr[MEM_AW-1:8] <= sh[MEM_AW-9:0];
            if (byte_end && state == S_ALO) ptr[7:0] <= sh;
            if (buf_wr) ptr[PAGE_AW-1:0] <= ptr[PAGE_AW-1:0] + 1'b1;
            if (state != S_PROG && nxt == S_PROG) prog_cnt <= CNT_W'(PROG_CYCLES - 1);
            else if (state == S_PROG && !commit) prog_cnt <= prog_cnt - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        sda_oe = (state == S_ACK_DEV) || (state == S_ACK_HI) ||
                 (state == S_ACK_LO)  || (state == S_ACK_DATA);
        busy   = (state == S_PROG);
    end

    i2cw_page_buf #(.PAGE_AW(PAGE_AW), .DW(8)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
        .wr_idx(ptr[PAGE_AW-1:0]), .wr_data(sh), .page_q(page_q), .valid(valid)
    );

    i2cw_nv_array #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .DW(8)) u_arr (
        .clk(clk), .commit(commit), .page_sel(ptr[MEM_AW-1:PAGE_AW]),
        .page_q(page_q), .valid(valid), .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker
    import i2cw_pkg::*;
#(
    parameter int PROG_CYCLES = 200,
    parameter int MEM_AW      = 9,
    parameter int PAGE_AW     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl,
    input logic              sda_oe,
    input logic              busy,
    input logic              start_evt,
    input logic              stop_evt,
    input wst_t              state,
    input logic [MEM_AW-1:0] ptr,
    input logic              buf_any
);
    logic [31:0] run;
    logic in_page;

    assign in_page = (state == S_DATA) || (state == S_ACK_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run <= '0;
        else        run <= busy ? run + 32'd1 : 32'd0;
    end

    a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl);

    a_r9_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    a_r8_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run == PROG_CYCLES);

    a_r6_page_high_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (in_page && $past(in_page)) |-> $stable(ptr[MEM_AW-1:PAGE_AW]));

    a_r10_start_drops_page: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !busy) |=> !buf_any);
endmodule

bind i2c_page_write_slave i2cw_checker #(
    .PROG_CYCLES(PROG_CYCLES), .MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)
) u_i2cw_chk (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda_oe(sda_oe), .busy(busy),
    .start_evt(start_evt), .stop_evt(stop_evt), .state(state),
    .ptr(ptr), .buf_any(buf_any)
);

// File: tb/test_i2c_page_write_slave.sv
`timescale 1ns/1ps
module test_i2c_page_write_slave;
    localparam int PROG = 600;
    localparam int Q    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic sda_oe, busy;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;
    wire sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int busy_run = 0;
    int last_len = 0;
    int rises = 0;
    int oe_bad = 0;
    logic scl_d = 1'b1, oe_d = 1'b0;

    always #4 clk = ~clk;

    i2c_page_write_slave #(.MEM_AW(9), .PAGE_AW(6), .PROG_CYCLES(PROG)) i_i2c_page_write_slave (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_line), .strap(strap),
        .sda_oe(sda_oe), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always @(negedge clk) begin
        if (busy) begin
            if (busy_run == 0) rises++;
            busy_run++;
        end else begin
            if (busy_run != 0) last_len = busy_run;
            busy_run = 0;
        end
        if (oe_d != sda_oe && scl_d) oe_bad++;
        oe_d  = sda_oe;
        scl_d = scl;
    end

    typedef struct packed {
        logic [7:0]  dev;
        logic [15:0] addr;
        logic [7:0]  data;
        logic        ack;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'hAA, 16'h0010, 8'h3C, 1'b1},
        '{8'hAA, 16'h0123, 8'h5A, 1'b1},
        '{8'hAA, 16'hF1FF, 8'hC3, 1'b1},
        '{8'hA2, 16'h0020, 8'h11, 1'b0},
        '{8'hAB, 16'h0021, 8'h22, 1'b0},
        '{8'hBA, 16'h0022, 8'h33, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic send_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(2*Q);
            scl = 1'b0;   tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        ack = !sda_line;
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    // Start, device byte, pointer, n data bytes (first + k*step); optional STOP.
    task automatic wr_txn(input logic [7:0] dev, input logic [15:0] addr, input int n,
                          input logic [7:0] first, input logic [7:0] step,
                          input bit do_stop, output int acks);
        logic a;
        acks = 0;
        send_start();
        send_byte(dev, a);        acks += int'(a);
        send_byte(addr[15:8], a); acks += int'(a);
        send_byte(addr[7:0], a);  acks += int'(a);
        for (int k = 0; k < n; k++) begin
            send_byte(first + 8'(k) * step, a);
            acks += int'(a);
        end
        if (do_stop) send_stop();
    endtask

    task automatic wait_idle();
        tick(10);
        while (busy) tick(1);
        tick(2);
    endtask

    task automatic peek(input logic [8:0] a, output logic [7:0] v);
        rd_addr = a;
        tick(1);
        v = rd_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int acks, r0;
        logic [7:0] v;
        logic a;

        tick(3);
        chk("R12", "sda_oe in reset", int'(sda_oe), 0);
        chk("R12", "busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        tick(5);
        chk("R12", "busy after reset", int'(busy), 0);

        // Vector table: single-byte writes, accepted and rejected
        for (int vi = 0; vi < 6; vi++) begin
            r0 = rises;
            wr_txn(VECS[vi].dev, VECS[vi].addr, 1, VECS[vi].data, 8'd0, 1'b1, acks);
            wait_idle();
            if (VECS[vi].ack) begin
                chk("R1 R4 R5", "ack count", acks, 4);
                chk("R8", "programming started", rises - r0, 1);
                chk("R8", "busy length", last_len, PROG);
                peek(VECS[vi].addr[8:0], v);
                chk("R4", "array byte", int'(v), int'(VECS[vi].data));
            end else begin
                chk("R2 R3", "acks on rejected txn", acks, 0);
                chk("R2 R3", "no programming", rises - r0, 0);
            end
        end

        // R6: page wrap keeps high bits
        wr_txn(8'hAA, 16'h0040, 1, 8'h77, 8'd0, 1'b1, acks); wait_idle();
        wr_txn(8'hAA, 16'h0C3E, 5, 8'hD0, 8'd1, 1'b1, acks); wait_idle();
        chk("R5", "page acks", acks, 8);
        peek(9'h03E, v); chk("R6", "loc 3E", int'(v), 'hD0);
        peek(9'h03F, v); chk("R6", "loc 3F", int'(v), 'hD1);
        peek(9'h000, v); chk("R6", "loc 00 wrapped", int'(v), 'hD2);
        peek(9'h002, v); chk("R6", "loc 02 wrapped", int'(v), 'hD4);
        peek(9'h040, v); chk("R6", "next page untouched", int'(v), 'h77);

        // R7: 66 bytes overwrite the first two slots
        wr_txn(8'hAA, 16'h0080, 66, 8'd1, 8'd1, 1'b1, acks); wait_idle();
        chk("R5", "acks on 66-byte burst", acks, 69);
        chk("R8", "busy length long page", last_len, PROG);
        peek(9'h080, v); chk("R7", "loc 80 last wins", int'(v), 65);
        peek(9'h081, v); chk("R7", "loc 81 last wins", int'(v), 66);
        peek(9'h082, v); chk("R7", "loc 82 kept", int'(v), 3);
        peek(9'h0BF, v); chk("R7", "loc BF", int'(v), 64);

        // R8/R9: deferred commit and bus ignored while busy
        wr_txn(8'hAA, 16'h0150, 1, 8'h01, 8'd0, 1'b1, acks); wait_idle();
        wr_txn(8'hAA, 16'h0150, 1, 8'h99, 8'd0, 1'b0, acks);
        peek(9'h150, v); chk("R8", "array before STOP", int'(v), 'h01);
        chk("R8", "busy before STOP", int'(busy), 0);
        send_stop();
        tick(8);
        chk("R8", "busy after STOP", int'(busy), 1);
        send_start();
        send_byte(8'hAA, a);
        chk("R9", "ack while busy", int'(a), 0);
        send_stop();
        wait_idle();
        peek(9'h150, v); chk("R8", "array after commit", int'(v), 'h99);

        // R10: repeated START aborts; STOP without data does not program
        r0 = rises;
        wr_txn(8'hAA, 16'h0150, 1, 8'h44, 8'd0, 1'b0, acks);
        send_start();
        send_stop();
        wait_idle();
        chk("R10", "no programming after abort", rises - r0, 0);
        peek(9'h150, v); chk("R10", "aborted byte not stored", int'(v), 'h99);
        wr_txn(8'hAA, 16'h0150, 0, 8'h00, 8'd0, 1'b1, acks);
        wait_idle();
        chk("R10", "no programming without data", rises - r0, 0);

        chk("R11", "sda_oe changes with SCL high", oe_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule